// File: doc/BRIEF.md
# PHY Status-Change Interrupt Controller

This block raises a single active-low interrupt request when one of four physical-layer status events occurs. It watches three level signals from the transceiver core (link up, 100 Mb/s speed, full duplex) and reports a change in either direction on any of them. It also watches a one-cycle pulse that marks the end of autonegotiation. Each event sets its own sticky status bit. The status bits stay set until software reads them.

Two 16-bit management registers control the block. The control register at address 18 holds a global interrupt-enable bit and four per-source mask bits. The read-only status register at address 19 holds the four latched event bits and clears itself when read. Both registers are reached through a plain register port with one-cycle write and read strobes and combinational read data. The request line is registered, so a glitch-free level can drive an open-drain style pad.

Top module: `phy_irq_ctrl`

## Requirements
- R1: After reset, the registers at addresses 18 and 19 both read 0x0000 and `irq_n` is 1.
- R2: Address 18 is read/write. Bit 1 is the global enable. Bits 4, 5, 6 and 7 are the masks for autonegotiation, speed, duplex and link, in that order. All other bits read 0, so writing 0xFFFF reads back as 0x00F2.
- R3: Address 19 is read-only. Bits 4, 5, 6 and 7 hold the latched autonegotiation, speed, duplex and link events, and all other bits read 0. A write to address 19 does not change its contents.
- R4: A rising or falling edge on `link_up`, `speed_100` or `full_duplex`, and any cycle with `an_done` high, sets the matching status bit at the next clock edge.
- R5: The levels present during reset and in the first cycle after reset are not reported as events.
- R6: A status bit stays set until address 19 is read. Reading address 18 does not clear it.
- R7: A read of address 19 returns the current status in the same cycle and clears it at the next edge. An event that arrives in the cycle of the read stays set.
- R8: `irq_n` goes low one cycle after a status bit and its mask bit are both 1 while the global enable is 1. This is two cycles after the event input changes.
- R9: While the global enable is 0, `irq_n` stays high. Status bits still latch. Setting the enable while events are pending drives `irq_n` low.
- R10: A status bit whose mask bit is 0 is latched but does not pull `irq_n` low.
- R11: `irq_n` returns high one cycle after the read that clears the last unmasked pending bit.
- R12: Addresses other than 18 and 19 read 0x0000, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives clear-on-read) |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| link_up | input | 1 | Link status level |
| speed_100 | input | 1 | Speed status level |
| full_duplex | input | 1 | Duplex status level |
| an_done | input | 1 | Autonegotiation-complete pulse |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The embedded assertions check the following on every cycle:
- A latched bit never drops except in the cycle after a status read.
- Every detected event appears in the status register one edge later.
- A write to the status register leaves it unchanged.
- A disabled block never drives the request low.
- A low request always traces back to an enabled, unmasked pending bit.

Only the bench scenarios can show the following:
- The register bit positions and the read-back value of the control register.
- Edges in both directions on each source, and levels present at reset being ignored.
- The exact two-cycle latency to the request.
- An event that collides with a read being preserved.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;

    // number of event sources and their index in every per-source vector
    localparam int NUM_SRC    = 4;
    localparam int SRC_AN     = 0;
    localparam int SRC_SPEED  = 1;
    localparam int SRC_DUPLEX = 2;
    localparam int SRC_LINK   = 3;

    // number of level-monitored sources (all but the autoneg pulse)
    localparam int NUM_LVL    = NUM_SRC - 1;

    // bit positions inside the control and status words
    localparam int GEN_BIT    = 1;
    localparam int SRC_LSB    = 4;

    typedef logic [NUM_SRC-1:0] src_vec_t;

endpackage

// File: rtl/phy_irq_edge.sv
module phy_irq_edge
    import phy_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LVL-1:0] lvl,
    input  logic               pulse,
    output src_vec_t           ev
);

    typedef struct packed {
        logic               primed;
        logic [NUM_LVL-1:0] prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.primed = 1'b1;
        st_d.prev   = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // level sources occupy ev[1..NUM_LVL]; the pulse source is ev[0]
    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        assign ev[g+1] = st_q.primed & (lvl[g] ^ st_q.prev[g]);
    end
    assign ev[SRC_AN] = st_q.primed & pulse;

endmodule

// File: rtl/phy_irq_regs.sv
module phy_irq_regs
    import phy_irq_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 16,
    parameter int CTRL_ADDR = 18,
    parameter int STAT_ADDR = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  src_vec_t          ev,
    output logic [DATA_W-1:0] rdata,
    output logic              gen_en,
    output src_vec_t          mask,
    output src_vec_t          stat
);

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

    typedef struct packed {
        logic     gen;
        src_vec_t mask;
        src_vec_t stat;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic    clr;
    logic    ctrl_wr;

    assign clr     = rd & (addr == STAT_A);
    assign ctrl_wr = wr & (addr == CTRL_A);

    always_comb begin
        st_d = st_q;
        if (ctrl_wr) begin
            st_d.gen  = wdata[GEN_BIT];
            st_d.mask = wdata[SRC_LSB +: NUM_SRC];
        end
        st_d.stat = (clr ? '0 : st_q.stat) | ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == CTRL_A) begin
            rdata[GEN_BIT]             = st_q.gen;
            rdata[SRC_LSB +: NUM_SRC]  = st_q.mask;
        end else if (addr == STAT_A) begin
            rdata[SRC_LSB +: NUM_SRC]  = st_q.stat;
        end
    end

    assign gen_en = st_q.gen;
    assign mask   = st_q.mask;
    assign stat   = st_q.stat;

    logic unused_wdata;
    assign unused_wdata = ^{wdata[DATA_W-1:SRC_LSB+NUM_SRC], wdata[SRC_LSB-1:GEN_BIT+1], wdata[0]};

    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((st_q.stat & $past(st_q.stat)) == $past(st_q.stat)));

    // R4
    event_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev != '0) |=> ((st_q.stat & $past(ev)) == $past(ev)));

    // R3
    stat_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == STAT_A && !clr && ev == '0) |=> $stable(st_q.stat));

    // R7
    read_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.stat == $past(ev)));

endmodule

// File: rtl/phy_irq_out.sv
module phy_irq_out
    import phy_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     gen_en,
    input  src_vec_t mask,
    input  src_vec_t stat,
    output logic     irq_n
);

    typedef struct packed {
        logic req_n;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.req_n = ~(gen_en & (|(mask & stat)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{req_n: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_n = st_q.req_n;

    // R9
    gen_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |=> irq_n);

endmodule

// File: rtl/phy_irq_ctrl.sv
module phy_irq_ctrl
    import phy_irq_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 16,
    parameter int CTRL_ADDR = 18,
    parameter int STAT_ADDR = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              link_up,
    input  logic              speed_100,
    input  logic              full_duplex,
    input  logic              an_done,
    output logic              irq_n
);

    src_vec_t ev;
    src_vec_t mask;
    src_vec_t stat;
    logic     gen_en;
    logic [NUM_LVL-1:0] lvl;

    // order follows the source indices: speed, duplex, link
    assign lvl = {link_up, full_duplex, speed_100};

    phy_irq_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (lvl),
        .pulse (an_done),
        .ev    (ev)
    );

    phy_irq_regs #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CTRL_ADDR (CTRL_ADDR),
        .STAT_ADDR (STAT_ADDR)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr),
        .rd     (reg_rd),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .ev     (ev),
        .rdata  (reg_rdata),
        .gen_en (gen_en),
        .mask   (mask),
        .stat   (stat)
    );

    phy_irq_out u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .gen_en (gen_en),
        .mask   (mask),
        .stat   (stat),
        .irq_n  (irq_n)
    );

    // R8
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> $past(gen_en && ((mask & stat) != '0)));

endmodule

// File: tb/phy_irq_ctrl_tb.sv
module phy_irq_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        link_up = 1'b1;
    logic        speed_100 = 1'b0;
    logic        full_duplex = 1'b0;
    logic        an_done = 1'b0;
    logic        irq_n;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    phy_irq_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .link_up     (link_up),
        .speed_100   (speed_100),
        .full_duplex (full_duplex),
        .an_done     (an_done),
        .irq_n       (irq_n)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        wait_n(3);
        check("R1 irq_n after reset", {15'd0, irq_n}, 16'h0001);
        rd(5'd18, v); check("R1 ctrl reset", v, 16'h0000);
        rd(5'd19, v); check("R5 no event from reset level", v, 16'h0000);
    endtask

    task automatic t_ctrl_rw();
        logic [15:0] v;
        wr(5'd18, 16'hFFFF); rd(5'd18, v); check("R2 ctrl readback", v, 16'h00F2);
        wr(5'd18, 16'h0000); rd(5'd18, v); check("R2 ctrl cleared", v, 16'h0000);
    endtask

    task automatic t_link_irq();
        logic [15:0] v;
        wr(5'd18, 16'h0082);
        link_up = 1'b0;
        wait_n(1); check("R8 irq_n not yet low", {15'd0, irq_n}, 16'h0001);
        wait_n(1); check("R8 irq_n low", {15'd0, irq_n}, 16'h0000);
        rd(5'd19, v); check("R4 link falling edge", v, 16'h0080);
        wait_n(1); check("R11 irq_n released", {15'd0, irq_n}, 16'h0001);
        rd(5'd19, v); check("R7 cleared by read", v, 16'h0000);
    endtask

    task automatic t_persist();
        logic [15:0] v;
        link_up = 1'b1;
        wait_n(5);
        rd(5'd18, v);
        wait_n(1);
        check("R6 irq_n still low", {15'd0, irq_n}, 16'h0000);
        rd(5'd19, v); check("R6 link bit held", v, 16'h0080);
        wait_n(1);
        rd(5'd19, v); check("R6 cleared after status read", v, 16'h0000);
    endtask

    task automatic t_sources();
        logic [15:0] v;
        wr(5'd18, 16'h00F2);
        speed_100 = 1'b1; wait_n(1);
        rd(5'd19, v); check("R4 speed rise", v, 16'h0020);
        full_duplex = 1'b1; wait_n(1);
        rd(5'd19, v); check("R4 duplex rise", v, 16'h0040);
        an_done = 1'b1; wait_n(1); an_done = 1'b0;
        rd(5'd19, v); check("R4 autoneg pulse", v, 16'h0010);
        speed_100 = 1'b0; wait_n(1);
        rd(5'd19, v); check("R4 speed fall", v, 16'h0020);
        full_duplex = 1'b0; wait_n(1);
        rd(5'd19, v); check("R4 duplex fall", v, 16'h0040);
        wait_n(2);
    endtask

    task automatic t_mask();
        logic [15:0] v;
        wr(5'd18, 16'h0022);
        link_up = 1'b0; wait_n(3);
        check("R10 masked source no irq", {15'd0, irq_n}, 16'h0001);
        rd(5'd19, v); check("R10 masked source latched", v, 16'h0080);
        speed_100 = 1'b1; wait_n(2);
        check("R10 unmasked source irq", {15'd0, irq_n}, 16'h0000);
        rd(5'd19, v);
        wait_n(1);
        check("R11 irq_n released after mask test", {15'd0, irq_n}, 16'h0001);
    endtask

    task automatic t_gen_off();
        logic [15:0] v;
        wr(5'd18, 16'h00F0);
        full_duplex = 1'b1; wait_n(3);
        check("R9 disabled no irq", {15'd0, irq_n}, 16'h0001);
        wr(5'd18, 16'h00F2); wait_n(1);
        check("R9 enable with pending", {15'd0, irq_n}, 16'h0000);
        wr(5'd18, 16'h00F0); wait_n(1);
        check("R9 disable again", {15'd0, irq_n}, 16'h0001);
        rd(5'd19, v); check("R9 status latched while disabled", v, 16'h0040);
    endtask

    task automatic t_same_cycle();
        logic [15:0] v;
        wr(5'd18, 16'h00F2);
        link_up = 1'b1; wait_n(2);
        reg_rd = 1'b1; reg_addr = 5'd19; speed_100 = 1'b0;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
        check("R7 read returns current", v, 16'h0080);
        rd(5'd19, v); check("R7 event during read kept", v, 16'h0020);
        wait_n(2);
    endtask

    task automatic t_stat_write();
        logic [15:0] v;
        full_duplex = 1'b0; wait_n(2);
        wr(5'd19, 16'hFFFF);
        wr(5'd19, 16'h0000);
        check("R3 irq stays low", {15'd0, irq_n}, 16'h0000);
        rd(5'd19, v); check("R3 write to status ignored", v, 16'h0040);
        wait_n(2);
    endtask

    task automatic t_other_addr();
        logic [15:0] v;
        wr(5'd5, 16'hFFFF);
        rd(5'd5, v); check("R12 unmapped reads zero", v, 16'h0000);
        rd(5'd18, v); check("R12 ctrl untouched", v, 16'h00F2);
        rd(5'd19, v); check("R12 status untouched", v, 16'h0000);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        t_reset();
        t_ctrl_rw();
        t_link_irq();
        t_persist();
        t_sources();
        t_mask();
        t_gen_off();
        t_same_cycle();
        t_stat_write();
        t_other_addr();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

endmodule